// File: doc/BRIEF.md
# CAN Error-State Interrupt Flag Logic

This block watches the error confinement state of a CAN controller and turns it into sticky interrupt flags. It compares the receive and transmit error counter values, supplied from elsewhere, against the error-passive and bus-off limits. A flag is raised when its condition begins. The CPU clears a flag by writing a one to the flag's bit position. A single error interrupt request is driven whenever an unmasked flag is set.

The bus-off flag is protected. While the controller is bus-off, the block counts runs of eleven consecutive recessive bits, sampled at a bit-time strobe. It refuses any CPU clear of the bus-off flag until 128 such runs have been seen. While bus-off is set, the two error-passive flags cannot be raised. A soft-reset control holds every flag, every edge detector, the recovery counters and the interrupt request at zero.

Flag vectors (`clr_w1c`, `irq_mask`, `flags`) share one bit layout: bit 0 is receive error passive, bit 1 is transmit error passive, bit 2 is bus-off.

Top module: `can_errflag_ctrl`

## Requirements
- R1: flags[0] is set at the clock edge where rx_err_cnt first becomes 128 or more (the counter was below 128 at the edge before), provided flags[2] is 0.
- R2: flags[1] is set at the clock edge where tx_err_cnt first enters 128..255 inclusive, provided flags[2] is 0. A value of 127 sets nothing.
- R3: flags[2] is set at the clock edge where the 9-bit tx_err_cnt first exceeds 255.
- R4: While flags[2] is 1, neither flags[0] nor flags[1] can go from 0 to 1, even when its counter condition begins.
- R5: A one in clr_w1c bit i clears flags[i] at that clock edge. A zero in clr_w1c leaves the flag unchanged.
- R6: A flag that has been cleared is not set again while its condition stays present. It sets again only after the condition has gone away and returned.
- R7: When a hardware set and a CPU clear hit the same flag in one cycle, the flag ends up set.
- R8: A clear of flags[2] is ignored until 128 runs of 11 consecutive recessive samples (bus_rec=1 with bit_stb=1) have been counted since bus-off was entered. A dominant sample restarts the current run. Cycles without bit_stb do not count.
- R9: err_irq is 1 exactly when some flags[i] is 1 and irq_mask[i] is 0, with err_irq updated at the same edge as the flags.
- R10: While soft_rst is 1, flags and err_irq are 0. The condition edge detectors are also held, so a condition that is still present after release sets its flag at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset, holds all flag state at zero while high |
| rx_err_cnt | input | 8 | Current receive error counter value |
| tx_err_cnt | input | 9 | Current transmit error counter value, bit 8 set above 255 |
| bit_stb | input | 1 | One-cycle strobe per sampled bus bit |
| bus_rec | input | 1 | Sampled bus level, 1 = recessive, valid with bit_stb |
| clr_w1c | input | 3 | Write-one-to-clear strobes per flag |
| irq_mask | input | 3 | Per-flag interrupt mask, 1 = masked |
| flags | output | 3 | Flag bits: 0 rx passive, 1 tx passive, 2 bus-off |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
A hardware set and a CPU write-one-to-clear can land on the same flag in the same cycle. The bench provokes this by driving the counter across its limit on the same cycle as the clear strobe. It does so for a receive passive flag and for the bus-off flag, and expects the flag to read 1 afterwards. A second collision is a CPU clear of bus-off arriving one bit short of the 128th recessive run, and then again right after the run completes. The bench judges it by reading the flag in the cycle after each clear attempt.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int FLAG_N = 3;
  localparam int IDX_RX = 0;
  localparam int IDX_TX = 1;
  localparam int IDX_BO = 2;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/can_err_cond.sv
module can_err_cond
  import can_err_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int TEC_W       = 9,
  parameter int PASSIVE_MIN = 128,
  parameter int BUSOFF_MIN  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic [REC_W-1:0] rx_err_cnt,
  input  logic [TEC_W-1:0] tx_err_cnt,
  output flag_vec_t        cond_rise
);
  localparam logic [REC_W-1:0] RX_LIM = REC_W'(PASSIVE_MIN);
  localparam logic [TEC_W-1:0] TX_LIM = TEC_W'(PASSIVE_MIN);
  localparam logic [TEC_W-1:0] BO_LIM = TEC_W'(BUSOFF_MIN);

  flag_vec_t cond_now, cond_prev;

  always_comb begin
    cond_now         = '0;
    cond_now[IDX_RX] = (rx_err_cnt >= RX_LIM);
    cond_now[IDX_TX] = (tx_err_cnt >= TX_LIM) && (tx_err_cnt < BO_LIM);
    cond_now[IDX_BO] = (tx_err_cnt >= BO_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) cond_prev <= '0;
    else                 cond_prev <= cond_now;
  end

  assign cond_rise = cond_now & ~cond_prev;

  // A rise cannot repeat on two consecutive edges: the condition is recorded.
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst || soft_rst)
    cond_rise[IDX_RX] |=> !cond_rise[IDX_RX]);
endmodule

// File: rtl/can_busoff_recov.sv
module can_busoff_recov #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic bit_stb,
  input  logic bus_rec,
  output logic recov_done
);
  localparam int BIT_W  = $clog2(RUN_LEN);
  localparam int RUNS_W = $clog2(RUN_COUNT + 1);
  localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(RUN_LEN - 1);
  localparam logic [RUNS_W-1:0] RUNS_MAX = RUNS_W'(RUN_COUNT);

  logic [BIT_W-1:0]  bit_cnt;
  logic [RUNS_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      bit_cnt <= '0;
      run_cnt <= '0;
    end else if (bit_stb) begin
      if (!bus_rec) begin
        bit_cnt <= '0;
      end else if (bit_cnt == BIT_LAST) begin
        bit_cnt <= '0;
        if (run_cnt != RUNS_MAX) run_cnt <= run_cnt + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign recov_done = (run_cnt == RUNS_MAX);

  assert_run_cap_R8: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUNS_MAX);
  assert_dominant_restart_R8: assert property (@(posedge clk) disable iff (rst || hold)
    (bit_stb && !bus_rec) |=> (bit_cnt == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst || hold)
    !bit_stb |=> $stable(run_cnt));
endmodule

// File: rtl/can_err_flagreg.sv
module can_err_flagreg
  import can_err_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      soft_rst,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  input  flag_vec_t clr_allow,
  input  flag_vec_t irq_mask,
  output flag_vec_t flags_q,
  output logic      err_irq
);
  flag_vec_t flags_d;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign flags_d[i] = set_vec[i] | (flags_q[i] & ~(clr_vec[i] & clr_allow[i]));
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      flags_q <= '0;
      err_irq <= 1'b0;
    end else begin
      flags_q <= flags_d;
      err_irq <= |(flags_d & ~irq_mask);
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (set_vec[IDX_RX] && clr_vec[IDX_RX]) |=> flags_q[IDX_RX]);
  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (clr_vec[IDX_TX] && clr_allow[IDX_TX] && !set_vec[IDX_TX]) |=> !flags_q[IDX_TX]);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |-> !err_irq);
  assert_soft_hold_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (flags_q == '0) && !err_irq);
endmodule

// File: rtl/can_errflag_ctrl.sv
module can_errflag_ctrl
  import can_err_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int TEC_W       = 9,
  parameter int PASSIVE_MIN = 128,
  parameter int BUSOFF_MIN  = 256,
  parameter int RUN_LEN     = 11,
  parameter int RUN_COUNT   = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic [REC_W-1:0] rx_err_cnt,
  input  logic [TEC_W-1:0] tx_err_cnt,
  input  logic             bit_stb,
  input  logic             bus_rec,
  input  logic [2:0]       clr_w1c,
  input  logic [2:0]       irq_mask,
  output logic [2:0]       flags,
  output logic             err_irq
);
  flag_vec_t rise, set_vec, allow, flags_q;
  logic      recov_done;

  can_err_cond #(
    .REC_W(REC_W), .TEC_W(TEC_W),
    .PASSIVE_MIN(PASSIVE_MIN), .BUSOFF_MIN(BUSOFF_MIN)
  ) u_cond (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .cond_rise(rise)
  );

  can_busoff_recov #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk(clk), .rst(rst), .hold(soft_rst || !flags_q[IDX_BO]),
    .bit_stb(bit_stb), .bus_rec(bus_rec), .recov_done(recov_done)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[IDX_RX] = rise[IDX_RX] & ~flags_q[IDX_BO];
    set_vec[IDX_TX] = rise[IDX_TX] & ~flags_q[IDX_BO];
    set_vec[IDX_BO] = rise[IDX_BO];
    allow           = '1;
    allow[IDX_BO]   = recov_done;
  end

  can_err_flagreg u_flags (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .set_vec(set_vec), .clr_vec(clr_w1c), .clr_allow(allow),
    .irq_mask(irq_mask), .flags_q(flags_q), .err_irq(err_irq)
  );

  assign flags = flags_q;

  assert_passive_blocked_R4: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (flags_q[IDX_BO] && !flags_q[IDX_RX]) |=> !flags_q[IDX_RX]);
  assert_busoff_hold_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (flags_q[IDX_BO] && !recov_done) |=> flags_q[IDX_BO]);
  assert_busoff_set_R3: assert property (@(posedge clk) disable iff (rst || soft_rst)
    rise[IDX_BO] |=> flags_q[IDX_BO]);
endmodule

// File: tb/tb_can_errflag_ctrl.sv
module tb_can_errflag_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic [7:0] rx_err_cnt = '0;
  logic [8:0] tx_err_cnt = '0;
  logic       bit_stb = 1'b0;
  logic       bus_rec = 1'b1;
  logic [2:0] clr_w1c = '0;
  logic [2:0] irq_mask = '0;
  logic [2:0] flags;
  logic       err_irq;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  can_errflag_ctrl dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .bit_stb(bit_stb), .bus_rec(bus_rec),
    .clr_w1c(clr_w1c), .irq_mask(irq_mask),
    .flags(flags), .err_irq(err_irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [2:0] v);
    clr_w1c = v; step(1); clr_w1c = '0;
  endtask

  task automatic send_bit(input logic lvl);
    bit_stb = 1'b1; bus_rec = lvl; step(1);
    bit_stb = 1'b0; bus_rec = 1'b1; step(1);
  endtask

  task automatic t_reset();
    step(3); rst = 1'b0; step(1);
    chk("R10 reset flags", int'(flags), 0);
    chk("R9 reset irq", int'(err_irq), 0);
  endtask

  task automatic t_rx_passive();
    rx_err_cnt = 8'd127; step(2);
    chk("R1 below limit", int'(flags[0]), 0);
    rx_err_cnt = 8'd128; step(1);
    chk("R1 rx set", int'(flags[0]), 1);
    chk("R9 irq unmasked", int'(err_irq), 1);
    rx_err_cnt = 8'd255;
    pulse_clr(3'b001);
    chk("R5 rx cleared", int'(flags[0]), 0);
    step(3);
    chk("R6 no re-set", int'(flags[0]), 0);
    chk("R9 irq gone", int'(err_irq), 0);
    rx_err_cnt = 8'd50; step(2);
    rx_err_cnt = 8'd200; clr_w1c = 3'b001; step(1); clr_w1c = '0;
    chk("R7 set beats clear rx", int'(flags[0]), 1);
    pulse_clr(3'b001);
    rx_err_cnt = 8'd0; step(1);
    chk("R5 rx clear again", int'(flags[0]), 0);
  endtask

  task automatic t_tx_passive();
    tx_err_cnt = 9'd127; step(2);
    chk("R2 127 no flag", int'(flags[1]), 0);
    tx_err_cnt = 9'd128; step(1);
    chk("R2 tx set", int'(flags[1]), 1);
    clr_w1c = 3'b000; step(2);
    chk("R5 zero write no effect", int'(flags[1]), 1);
    irq_mask = 3'b010; step(1);
    chk("R9 masked irq", int'(err_irq), 0);
    irq_mask = 3'b101; step(1);
    chk("R9 unmasked tx irq", int'(err_irq), 1);
    irq_mask = 3'b000;
    pulse_clr(3'b010);
    chk("R5 tx cleared", int'(flags[1]), 0);
  endtask

  task automatic t_busoff();
    tx_err_cnt = 9'd256; step(1);
    chk("R3 busoff set", int'(flags[2]), 1);
    chk("R3 tx passive idle", int'(flags[1]), 0);
    rx_err_cnt = 8'd200; tx_err_cnt = 9'd200; step(2);
    chk("R4 rx blocked", int'(flags[0]), 0);
    chk("R4 tx blocked", int'(flags[1]), 0);
    tx_err_cnt = 9'd300; step(1);
    pulse_clr(3'b100);
    chk("R8 early clear ignored", int'(flags[2]), 1);
    for (int r = 0; r < 127; r++)
      for (int b = 0; b < 11; b++) send_bit(1'b1);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    send_bit(1'b0);
    step(3);
    pulse_clr(3'b100);
    chk("R8 dominant restarts run", int'(flags[2]), 1);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    pulse_clr(3'b100);
    chk("R8 one bit short", int'(flags[2]), 1);
    send_bit(1'b1);
    pulse_clr(3'b100);
    chk("R8 recovered clear", int'(flags[2]), 0);
    step(2);
    chk("R6 busoff stays clear", int'(flags[2]), 0);
    rx_err_cnt = 8'd0; tx_err_cnt = 9'd0; step(2);
    tx_err_cnt = 9'd400; clr_w1c = 3'b100; step(1); clr_w1c = '0;
    chk("R7 set beats clear busoff", int'(flags[2]), 1);
  endtask

  task automatic t_soft();
    soft_rst = 1'b1; step(1);
    chk("R10 soft clears flags", int'(flags), 0);
    chk("R10 soft clears irq", int'(err_irq), 0);
    rx_err_cnt = 8'd150; step(3);
    chk("R10 soft holds", int'(flags), 0);
    soft_rst = 1'b0; step(1);
    chk("R10 rise after release", int'(flags), 5);
    chk("R9 irq after release", int'(err_irq), 1);
    pulse_clr(3'b100);
    chk("R8 fresh count after soft", int'(flags[2]), 1);
  endtask

  initial begin
    t_reset();
    t_rx_passive();
    t_tx_passive();
    t_busoff();
    t_soft();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule